// File: doc/BRIEF.md
# I2C Bus Master Controller

This block is a single-master-role controller for a two-wire serial bus. It never drives either wire high: each of its two outputs is a pull-low enable for an open-drain line. It reads back the true level of both lines, so it can wait out a slave that holds the clock low and can see another master winning the bus.

A host issues one command at a time: start (or repeated start, chosen by the block itself when a transfer is already open), write a byte, read a byte with a host-chosen acknowledge value, or stop. Each command finishes with a one-cycle done pulse. Alongside that pulse the block reports the received byte, the acknowledge bit the slave returned after a write, and whether arbitration was lost. A 16-bit divider input sets the length of the basic delay unit. Every bit cycle is built from this unit.

Top module: `i2c_bus_master`

## Requirements
- R1: After reset both pull-low outputs are 0 (lines released), busy is 0, done is 0, inTransfer is 0 and arbLost is 0.
- R2: A start command from an idle bus checks that SDA reads high. It then makes the only SDA high-to-low transition of the command while SCL is high, leaves SCL pulled low, and sets inTransfer to 1.
- R3: A write command (cmdOp = 2'd1) sends cmdData MSB first over 8 SCL high phases, with SDA changing only while SCL is low. In a ninth SCL high phase it releases SDA and samples it into ackSeen, where 0 means ACK.
- R4: A read command (cmdOp = 2'd2) samples SDA in 8 SCL high phases, MSB first, and presents the byte on rxData with done. In a ninth phase it sends cmdAckBit on SDA, where 1 means NACK.
- R5: A stop command (cmdOp = 2'd3) pulls SDA low while SCL is low, then releases SCL. Its only SDA transition while SCL is high is low-to-high. When it completes, inTransfer is 0.
- R6: A start command (cmdOp = 2'd0) issued while inTransfer is 1 performs a repeated start. It raises SCL with SDA released, makes exactly one SDA falling edge while SCL is high, and inTransfer stays 1.
- R7: While the block has released SCL but SCL still reads low, the bit cycle is held. Lengthening a slave's clock hold by N cycles lengthens the command by exactly N cycles.
- R8: If SDA reads 0 during an SCL high phase in which the block is sending a 1, the block ends the command. It asserts done with arbLost = 1, releases both lines, clears inTransfer and sends no stop.
- R9: If SDA already reads 0 when a start is about to pull it low, the start ends with done, arbLost = 1 and inTransfer = 0.
- R10: With d = max(divider, 1), SCL is released for exactly d+1 clock cycles in each bit cycle when no slave stretches the clock, so a byte command releases SCL for 9(d+1) cycles.
- R11: A command is taken when cmdValid is high and busy is low. busy stays high until the command ends. done is a one-cycle pulse with busy low, and a new command clears arbLost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 2 | 0 start, 1 write, 2 read, 3 stop |
| cmdData | input | 8 | Byte to write |
| cmdAckBit | input | 1 | Acknowledge value sent after a read byte |
| divider | input | 16 | Delay unit length in cycles (0 acts as 1) |
| sclIn | input | 1 | Level read back from SCL |
| sdaIn | input | 1 | Level read back from SDA |
| sclDriveLow | output | 1 | Pull SCL low when 1 |
| sdaDriveLow | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| rxData | output | 8 | Last byte read |
| ackSeen | output | 1 | Acknowledge bit sampled after the last write |
| arbLost | output | 1 | Last command lost arbitration |
| inTransfer | output | 1 | A start has been issued and not yet closed |

## Verification
Two functions can fall in the same cycle. The sample that checks a transmitted 1 against the bus is the same cycle in which the block leaves its clock-stretch wait. So arbitration loss and the end of a stretched high phase coincide. The bench provokes this with a wired-AND model in which a rival pulls SDA low during a bit where the block sends a 1. It also has a slave hold SCL low for two different lengths on the same bit. The first case is judged by done arriving with arbLost set and both lines released. The second is judged by the difference in command latency, which must equal the difference in hold length.

// File: rtl/i2c_bus_master_pkg.sv
package i2c_bus_master_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } cmdOp_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic timerGo;
    logic sclPull;
    logic sclRelease;
    logic sdaPull;
    logic sdaRelease;
    logic shiftLoad;
    logic shiftIn;
    logic rxCapture;
  } dpStrobe_t;

endpackage

// File: rtl/i2c_bus_master_datapath.sv
module i2c_bus_master_datapath
  import i2c_bus_master_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divider,
  input  logic [BYTE_W-1:0] cmdData,
  input  logic              sdaIn,
  input  dpStrobe_t         strobe,
  output logic              timerDone,
  output logic              txBit,
  output logic [BYTE_W-1:0] rxData,
  output logic              sclDriveLow,
  output logic              sdaDriveLow
);

  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0]  timerQ;
  logic [DIV_W-1:0]  reloadVal;
  logic [BYTE_W-1:0] shiftQ;
  logic [BYTE_W-1:0] rxQ;
  logic              sclLowQ;
  logic              sdaLowQ;

  assign reloadVal = (divider == '0) ? ONE : divider;
  assign timerDone = (timerQ == ONE);

  // Delay unit: loaded on timerGo, counts down to 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerQ <= '0;
    end else if (strobe.timerGo) begin
      timerQ <= reloadVal;
    end else if (timerQ != '0) begin
      timerQ <= timerQ - ONE;
    end
  end

  // Shared shift register: transmit MSB first, receive into LSB
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      rxQ    <= '0;
    end else begin
      if (strobe.shiftLoad) begin
        shiftQ <= cmdData;
      end else if (strobe.shiftIn) begin
        shiftQ <= {shiftQ[BYTE_W-2:0], sdaIn};
      end
      if (strobe.rxCapture) begin
        rxQ <= shiftQ;
      end
    end
  end

  // Open-drain enables: only pull-low or release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclLowQ <= 1'b0;
      sdaLowQ <= 1'b0;
    end else begin
      if (strobe.sclPull)         sclLowQ <= 1'b1;
      else if (strobe.sclRelease) sclLowQ <= 1'b0;
      if (strobe.sdaPull)         sdaLowQ <= 1'b1;
      else if (strobe.sdaRelease) sdaLowQ <= 1'b0;
    end
  end

  assign txBit       = shiftQ[BYTE_W-1];
  assign rxData      = rxQ;
  assign sclDriveLow = sclLowQ;
  assign sdaDriveLow = sdaLowQ;

  // R10: once loaded, the delay counter only moves downward until reloaded
  p_timer_descends_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.timerGo && timerQ != '0) |=> (timerQ < $past(timerQ)));

  // R1: a line is never pulled and released in the same step
  p_no_conflicting_strobes_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.sdaPull && strobe.sdaRelease) && !(strobe.sclPull && strobe.sclRelease));

endmodule

// File: rtl/i2c_bus_master_control.sv
module i2c_bus_master_control
  import i2c_bus_master_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       cmdAckBit,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       timerDone,
  input  logic       txBit,
  output dpStrobe_t  strobe,
  output logic       busy,
  output logic       done,
  output logic       ackSeen,
  output logic       arbLost,
  output logic       inTransfer
);

  localparam int IDX_W = $clog2(BYTE_W + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W);

  typedef enum logic [4:0] {
    S_IDLE, S_RS_REL, S_RS_LOW, S_RS_STRETCH, S_RS_HIGH,
    S_ST_CHECK, S_ST_HOLD,
    S_BIT_SET, S_BIT_LOW, S_BIT_STRETCH, S_BIT_HIGH,
    S_SP_PULL, S_SP_LOW, S_SP_STRETCH, S_SP_HIGH, S_SP_CHECK
  } state_e;

  state_e           stateQ, stateNext;
  cmdOp_e           opQ;
  logic             ackBitQ;
  logic [IDX_W-1:0] bitIdxQ;
  logic             ackQ, arbQ, inTransferQ, doneQ;

  logic accept, finish, abort, ackCap, bitInc, setInT, clrInT;
  logic isWrite, lastBit, masterDrives, level, sendsOne;

  assign isWrite      = (opQ == OP_WRITE);
  assign lastBit      = (bitIdxQ == LAST_IDX);
  assign masterDrives = isWrite ? !lastBit : lastBit;
  assign level        = isWrite ? txBit : ackBitQ;
  assign sendsOne     = masterDrives && level;

  always_comb begin
    strobe    = '0;
    stateNext = stateQ;
    accept    = 1'b0;
    finish    = 1'b0;
    abort     = 1'b0;
    ackCap    = 1'b0;
    bitInc    = 1'b0;
    setInT    = 1'b0;
    clrInT    = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        if (cmdValid) begin
          accept           = 1'b1;
          strobe.shiftLoad = 1'b1;
          unique case (cmdOp_e'(cmdOp))
            OP_START: stateNext = inTransferQ ? S_RS_REL : S_ST_CHECK;
            OP_WRITE: stateNext = S_BIT_SET;
            OP_READ:  stateNext = S_BIT_SET;
            OP_STOP:  stateNext = S_SP_PULL;
          endcase
        end
      end
      // repeated start: raise SDA, then SCL, then fall into start edge
      S_RS_REL: begin
        strobe.sdaRelease = 1'b1;
        strobe.timerGo    = 1'b1;
        stateNext         = S_RS_LOW;
      end
      S_RS_LOW: if (timerDone) begin
        strobe.sclRelease = 1'b1;
        stateNext         = S_RS_STRETCH;
      end
      S_RS_STRETCH: if (sclIn) begin
        strobe.timerGo = 1'b1;
        stateNext      = S_RS_HIGH;
      end
      S_RS_HIGH: if (timerDone) stateNext = S_ST_CHECK;
      S_ST_CHECK: begin
        if (sclIn) begin
          if (!sdaIn) begin
            abort = 1'b1;
          end else begin
            strobe.sdaPull = 1'b1;
            strobe.timerGo = 1'b1;
            stateNext      = S_ST_HOLD;
          end
        end
      end
      S_ST_HOLD: if (timerDone) begin
        strobe.sclPull = 1'b1;
        setInT         = 1'b1;
        finish         = 1'b1;
      end
      // one bit cycle
      S_BIT_SET: begin
        if (masterDrives && !level) strobe.sdaPull = 1'b1;
        else                        strobe.sdaRelease = 1'b1;
        strobe.timerGo = 1'b1;
        stateNext      = S_BIT_LOW;
      end
      S_BIT_LOW: if (timerDone) begin
        strobe.sclRelease = 1'b1;
        stateNext         = S_BIT_STRETCH;
      end
      S_BIT_STRETCH: begin
        if (sclIn) begin
          if (sendsOne && !sdaIn) begin
            abort = 1'b1;
          end else begin
            if (!lastBit) strobe.shiftIn = 1'b1;
            if (lastBit && isWrite) ackCap = 1'b1;
            strobe.timerGo = 1'b1;
            stateNext      = S_BIT_HIGH;
          end
        end
      end
      S_BIT_HIGH: if (timerDone) begin
        strobe.sclPull = 1'b1;
        if (lastBit) begin
          strobe.rxCapture = !isWrite;
          finish           = 1'b1;
        end else begin
          bitInc    = 1'b1;
          stateNext = S_BIT_SET;
        end
      end
      // stop condition
      S_SP_PULL: begin
        strobe.sdaPull = 1'b1;
        strobe.timerGo = 1'b1;
        stateNext      = S_SP_LOW;
      end
      S_SP_LOW: if (timerDone) begin
        strobe.sclRelease = 1'b1;
        stateNext         = S_SP_STRETCH;
      end
      S_SP_STRETCH: if (sclIn) begin
        strobe.timerGo = 1'b1;
        stateNext      = S_SP_HIGH;
      end
      S_SP_HIGH: if (timerDone) begin
        strobe.sdaRelease = 1'b1;
        strobe.timerGo    = 1'b1;
        stateNext         = S_SP_CHECK;
      end
      S_SP_CHECK: if (timerDone) begin
        if (!sdaIn) begin
          abort = 1'b1;
        end else begin
          clrInT = 1'b1;
          finish = 1'b1;
        end
      end
      default: stateNext = S_IDLE;
    endcase
    if (abort) begin
      strobe.sclRelease = 1'b1;
      strobe.sdaRelease = 1'b1;
      strobe.sclPull    = 1'b0;
      strobe.sdaPull    = 1'b0;
      strobe.timerGo    = 1'b0;
      finish            = 1'b1;
    end
    if (finish) stateNext = S_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= S_IDLE;
      opQ         <= OP_START;
      ackBitQ     <= 1'b0;
      bitIdxQ     <= '0;
      ackQ        <= 1'b0;
      arbQ        <= 1'b0;
      inTransferQ <= 1'b0;
      doneQ       <= 1'b0;
    end else begin
      stateQ <= stateNext;
      doneQ  <= finish;
      if (accept) begin
        opQ     <= cmdOp_e'(cmdOp);
        ackBitQ <= cmdAckBit;
        bitIdxQ <= '0;
        arbQ    <= 1'b0;
      end
      if (bitInc) bitIdxQ <= bitIdxQ + 1'b1;
      if (ackCap) ackQ <= sdaIn;
      if (setInT) inTransferQ <= 1'b1;
      if (clrInT) inTransferQ <= 1'b0;
      if (abort) begin
        arbQ        <= 1'b1;
        inTransferQ <= 1'b0;
      end
    end
  end

  assign busy       = (stateQ != S_IDLE);
  assign done       = doneQ;
  assign ackSeen    = ackQ;
  assign arbLost    = arbQ;
  assign inTransfer = inTransferQ;

  // R7: a low SCL read-back holds the bit cycle in its wait state
  p_stretch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_BIT_STRETCH && !sclIn) |=> (stateQ == S_BIT_STRETCH));

  // R11: done lasts a single cycle and comes with busy low
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy ##1 !done));

  // R5: a stop that sees SDA high closes the transfer
  p_stop_closes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_SP_CHECK && timerDone && sdaIn) |=> (done && !inTransfer && !arbLost));

  // R8: sending a 1 against a low SDA ends the command with arbitration lost
  p_arb_detect_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_BIT_STRETCH && sclIn && sendsOne && !sdaIn) |=> (done && arbLost && !inTransfer));

endmodule

// File: rtl/i2c_bus_master.sv
module i2c_bus_master
  import i2c_bus_master_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [BYTE_W-1:0] cmdData,
  input  logic              cmdAckBit,
  input  logic [DIV_W-1:0]  divider,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rxData,
  output logic              ackSeen,
  output logic              arbLost,
  output logic              inTransfer
);

  dpStrobe_t strobe;
  logic      timerDone;
  logic      txBit;

  i2c_bus_master_control #(.BYTE_W(BYTE_W)) u_control (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAckBit(cmdAckBit), .sclIn(sclIn), .sdaIn(sdaIn),
    .timerDone(timerDone), .txBit(txBit), .strobe(strobe),
    .busy(busy), .done(done), .ackSeen(ackSeen), .arbLost(arbLost),
    .inTransfer(inTransfer)
  );

  i2c_bus_master_datapath #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_datapath (
    .clk(clk), .rstN(rstN), .divider(divider), .cmdData(cmdData),
    .sdaIn(sdaIn), .strobe(strobe), .timerDone(timerDone), .txBit(txBit),
    .rxData(rxData), .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow)
  );

  // R8: an aborted command leaves both lines released
  p_abort_released_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && arbLost) |-> (!sclDriveLow && !sdaDriveLow));

endmodule

// File: tb/i2c_bus_master_bench.sv
module i2c_bus_master_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [7:0]  cmdData = 8'h00;
  logic        cmdAckBit = 1'b0;
  logic [15:0] divider = 16'd4;
  logic        sclIn, sdaIn;
  logic        sclDriveLow, sdaDriveLow, busy, done, ackSeen, arbLost, inTransfer;
  logic [7:0]  rxData;

  logic        slaveSclLow = 1'b0;
  logic        slaveSdaLow = 1'b0;
  logic [8:0]  slvPat = '0;
  int          slvIdx = 0;
  int          stretchBit = 0;
  int          stretchLen = 0;
  logic [8:0]  capBits = '0;
  int          capCount = 0;
  int          startEdges = 0;
  int          stopEdges = 0;
  int          checks = 0;
  int          fails = 0;
  int          lat = 0;
  int          highCnt = 0;
  logic        busySeen = 1'b0;
  logic        timedOut = 1'b0;

  always #4 clk = ~clk;

  assign sclIn = !(sclDriveLow || slaveSclLow);
  assign sdaIn = !(sdaDriveLow || slaveSdaLow);

  i2c_bus_master u_i2c_bus_master (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .cmdAckBit(cmdAckBit), .divider(divider),
    .sclIn(sclIn), .sdaIn(sdaIn), .sclDriveLow(sclDriveLow),
    .sdaDriveLow(sdaDriveLow), .busy(busy), .done(done), .rxData(rxData),
    .ackSeen(ackSeen), .arbLost(arbLost), .inTransfer(inTransfer)
  );

  // Slave / rival model: change SDA after each SCL fall, optional clock hold
  always @(negedge sclIn) begin
    if (slvIdx < 9) slvIdx = slvIdx + 1;
    slaveSdaLow = (slvIdx <= 8) ? slvPat[8 - slvIdx] : 1'b0;
    if (stretchLen != 0 && slvIdx == stretchBit) begin
      fork
        begin
          slaveSclLow = 1'b1;
          repeat (stretchLen) @(posedge clk);
          @(negedge clk);
          slaveSclLow = 1'b0;
        end
      join_none
    end
  end

  always @(posedge sclIn) begin
    capBits  = {capBits[7:0], sdaIn};
    capCount = capCount + 1;
  end

  always @(negedge sdaIn) if (sclIn) startEdges = startEdges + 1;
  always @(posedge sdaIn) if (sclIn) stopEdges = stopEdges + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runCmd(input logic [1:0] op, input logic [7:0] data,
                        input logic ack, input logic [8:0] pat);
    @(negedge clk);
    slvPat      = pat;
    slvIdx      = 0;
    slaveSdaLow = pat[8];
    capBits     = '0;
    capCount    = 0;
    cmdOp       = op;
    cmdData     = data;
    cmdAckBit   = ack;
    cmdValid    = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    lat      = 1;
    busySeen = busy;
    highCnt  = sclDriveLow ? 0 : 1;
    while (!done && lat < 20000) begin
      @(negedge clk);
      lat++;
      if (!done && !sclDriveLow) highCnt++;
    end
    if (!done) begin
      timedOut = 1'b1;
      check("R11 watchdog", 32'd0, 32'd1);
    end
  endtask

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] data;
    logic       ackBit;
    logic [8:0] pat;
    logic [8:0] expCap;
    logic       expAck;
    logic [7:0] expRx;
    logic       expInT;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 8'h00, 1'b0, 9'h000, 9'h000, 1'b0, 8'h00, 1'b1},
    '{2'd1, 8'hA6, 1'b0, 9'h001, 9'h14C, 1'b0, 8'h00, 1'b1},
    '{2'd1, 8'h3C, 1'b0, 9'h000, 9'h079, 1'b1, 8'h00, 1'b1},
    '{2'd0, 8'h00, 1'b0, 9'h000, 9'h000, 1'b0, 8'h00, 1'b1},
    '{2'd1, 8'hA7, 1'b0, 9'h001, 9'h14E, 1'b0, 8'h00, 1'b1},
    '{2'd2, 8'h00, 1'b0, 9'h14A, 9'h0B4, 1'b0, 8'h5A, 1'b1},
    '{2'd2, 8'h00, 1'b1, 9'h078, 9'h187, 1'b0, 8'hC3, 1'b1},
    '{2'd3, 8'h00, 1'b0, 9'h000, 9'h000, 1'b0, 8'h00, 1'b0}
  };

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("R11 global watchdog", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    int s0, p0, latA, latB;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 sclDriveLow", 32'(sclDriveLow), 0);
    check("R1 sdaDriveLow", 32'(sdaDriveLow), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 done", 32'(done), 0);
    check("R1 inTransfer", 32'(inTransfer), 0);
    check("R1 arbLost", 32'(arbLost), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: start, writes, repeated start, reads, stop
    divider = 16'd4;
    for (int i = 0; i < 8; i++) begin
      s0 = startEdges;
      p0 = stopEdges;
      runCmd(VEC[i].op, VEC[i].data, VEC[i].ackBit, VEC[i].pat);
      check("R11 busy during command", 32'(busySeen), 1);
      check("R11 busy low at done", 32'(busy), 0);
      check("R8 no arbitration loss", 32'(arbLost), 0);
      check("R2 R6 start edges", 32'(startEdges - s0), (VEC[i].op == 2'd0) ? 1 : 0);
      check("R5 stop edges", 32'(stopEdges - p0), (VEC[i].op == 2'd3) ? 1 : 0);
      check("R2 R5 R6 inTransfer", 32'(inTransfer), 32'(VEC[i].expInT));
      if (VEC[i].op == 2'd1) begin
        check("R3 bits on bus", 32'(capBits), 32'(VEC[i].expCap));
        check("R3 ackSeen", 32'(ackSeen), 32'(VEC[i].expAck));
        check("R10 scl released d4", 32'(highCnt), 45);
      end
      if (VEC[i].op == 2'd2) begin
        check("R4 bits on bus", 32'(capBits), 32'(VEC[i].expCap));
        check("R4 rxData", 32'(rxData), 32'(VEC[i].expRx));
      end
      if (VEC[i].op != 2'd0 && VEC[i].op != 2'd3)
        check("R3 R4 nine phases", 32'(capCount), 9);
      @(negedge clk);
      check("R11 done one cycle", 32'(done), 0);
      if (VEC[i].op == 2'd3) begin
        check("R5 lines released sda", 32'(sdaDriveLow), 0);
        check("R5 lines released scl", 32'(sclDriveLow), 0);
      end
    end

    // R10: divider 0 behaves as 1
    divider = 16'd0;
    runCmd(2'd0, 8'h00, 1'b0, 9'h000);
    runCmd(2'd1, 8'h55, 1'b0, 9'h001);
    check("R10 scl released d0", 32'(highCnt), 18);
    check("R10 R3 bits d0", 32'(capBits), 32'h0AA);
    runCmd(2'd3, 8'h00, 1'b0, 9'h000);

    // R7: clock stretching adds exactly the extra hold time
    divider = 16'd4;
    runCmd(2'd0, 8'h00, 1'b0, 9'h000);
    stretchBit = 3;
    stretchLen = 40;
    runCmd(2'd1, 8'h96, 1'b0, 9'h001);
    latA = lat;
    check("R7 bits with stretch", 32'(capBits), 32'h12C);
    stretchLen = 60;
    runCmd(2'd1, 8'h96, 1'b0, 9'h001);
    latB = lat;
    check("R7 latency difference", 32'(latB - latA), 20);
    check("R7 ack with stretch", 32'(ackSeen), 0);
    stretchLen = 0;
    runCmd(2'd3, 8'h00, 1'b0, 9'h000);

    // R8: rival pulls SDA during a transmitted 1 (bit cycle 2)
    runCmd(2'd0, 8'h00, 1'b0, 9'h000);
    p0 = stopEdges;
    runCmd(2'd1, 8'hFF, 1'b0, 9'h040);
    check("R8 arbLost", 32'(arbLost), 1);
    check("R8 inTransfer cleared", 32'(inTransfer), 0);
    check("R8 scl released", 32'(sclDriveLow), 0);
    check("R8 sda released", 32'(sdaDriveLow), 0);
    check("R8 no stop sent", 32'(stopEdges - p0), 0);
    check("R8 fewer phases", 32'(capCount), 3);
    @(negedge clk);
    slaveSdaLow = 1'b0;
    repeat (2) @(negedge clk);

    // R9: SDA already low at start
    runCmd(2'd0, 8'h00, 1'b0, 9'h100);
    check("R9 arbLost", 32'(arbLost), 1);
    check("R9 inTransfer", 32'(inTransfer), 0);
    check("R9 sda released", 32'(sdaDriveLow), 0);
    @(negedge clk);
    slaveSdaLow = 1'b0;
    repeat (2) @(negedge clk);
    // R11: next command clears arbLost
    runCmd(2'd0, 8'h00, 1'b0, 9'h000);
    check("R11 arbLost cleared", 32'(arbLost), 0);
    check("R2 start after loss", 32'(inTransfer), 1);
    runCmd(2'd3, 8'h00, 1'b0, 9'h000);
    check("R5 final stop", 32'(inTransfer), 0);

    if (timedOut) $display("watchdog expired in a command");
    finishRun();
  end

endmodule